// File: doc/BRIEF.md
# Float-to-Unsigned Wrapping Converter

This block is a pipelined execution unit that turns an IEEE binary floating-point operand into an unsigned integer of the same width. One build handles 32-, 64- and 128-bit operands. A size code is sampled with a valid strobe, together with a rounding-mode code, the operand and a caller tag. The unit does not clamp results that are out of range. It returns the exact rounded integer reduced modulo 2^N, where N is the operand width. Negative inputs produce the two's-complement pattern of their rounded value. Three flag bits come with every result: inexact, overflow and invalid.

The latency depends on the size: 3 cycles for 32-bit operands, 4 for 64-bit and 5 for 128-bit. A new operation can be accepted every cycle. A short operation issued just after a long one can therefore finish first. The tag returned with each result lets the caller match results to requests. The issuer must not start an operation that would complete in the same cycle as one already in flight.

Top module: `fp2uint_wrap`

## Requirements
- R1: Size code 0 selects binary32, held in operand bits [31:0]. Code 1 selects binary64, held in bits [63:0]. Codes 2 and 3 select binary128, held in bits [127:0]. Operand bits above the selected width are ignored. Result bits at and above N are 0. An in-range value converts to its rounded integer.
- R2: Rounding-mode codes are 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf and 4 nearest with ties away from zero. Codes 5 to 7 behave as code 0.
- R3: When a positive finite value rounds to an integer of 2^N or more, the result is that integer modulo 2^N and flag bit 1 (overflow) is set.
- R4: A negative finite value returns the low N bits of the two's complement of its rounded magnitude. Flag bit 1 is set whenever that magnitude is nonzero. Minus zero gives 0 with no flag.
- R5: Flag bit 0 (inexact) is set exactly when the rounding discards nonzero fraction bits. Exact conversions leave it clear.
- R6: A result appears on the outputs 3, 4 or 5 cycles after its operand is sampled, for 32-, 64- and 128-bit sizes respectively. The tag captured at input comes out with it. One operation is accepted per cycle.
- R7: A NaN or infinity returns 0 with flag bit 2 (invalid) set and flag bits 1 and 0 clear.
- R8: Subnormal inputs are converted as ordinary values and round to 0 or 1 according to the mode.
- R9: Results leave the unit in completion order, not issue order. Two completions never share a cycle, provided the issuer avoids such schedules.
- R10: During and after reset, with no operation issued, out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_size | input | 2 | Operand size code |
| in_rmode | input | 3 | Rounding-mode code |
| in_operand | input | 128 | Floating-point operand, right-aligned |
| in_tag | input | TAG_W | Caller tag returned with the result |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Unsigned integer result, zero above N |
| out_flags | output | 3 | {invalid, overflow, inexact} |
| out_tag | output | TAG_W | Tag of the completing operation |

## Verification
The bench builds the unit with its default tag width of 4 bits. That lets a 128-bit and a 32-bit operation carry distinct tags and exposes the order in which they overtake each other. Operand size is an input, not a parameter, so one build covers all three formats, including their wrap, negative, subnormal and special encodings. The binary64 results in nearest-away mode are also compared against the simulator's own real-to-integer conversion.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;
  localparam int OP_W   = 128;              // widest operand / result
  localparam int SIG_W  = 113;              // significand incl. hidden bit
  localparam int EXP_W  = 18;               // signed unbiased exponent
  localparam int FRAC_W = SIG_W + 1;        // fraction part of fixed-point window
  localparam int FIX_W  = OP_W + FRAC_W;    // full fixed-point window
  localparam int FLAG_W = 3;
  localparam int W_S    = 32;
  localparam int W_D    = 64;

  typedef enum logic [2:0] {
    RM_NE = 3'd0, RM_TZ = 3'd1, RM_UP = 3'd2, RM_DN = 3'd3, RM_NA = 3'd4
  } rmode_e;

  // extra cycles beyond the common three-stage path
  function automatic logic [1:0] extra_lat(input logic [1:0] sz);
    return (sz == 2'd0) ? 2'd0 : (sz == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/fp2u_unpack.sv
module fp2u_unpack
  import fp2u_pkg::*;
(
  input  logic [OP_W-1:0]         op_i,
  input  logic [1:0]              size_i,
  output logic                    sign_o,
  output logic                    special_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  logic [14:0]      bexp;
  logic [14:0]      bias;
  logic [SIG_W-2:0] frac;
  logic             hidden;

  always_comb begin
    unique case (size_i)
      2'd0: begin
        sign_o    = op_i[31];
        bexp      = {7'd0, op_i[30:23]};
        special_o = &op_i[30:23];
        bias      = 15'd127;
        frac      = {op_i[22:0], 89'd0};
      end
      2'd1: begin
        sign_o    = op_i[63];
        bexp      = {4'd0, op_i[62:52]};
        special_o = &op_i[62:52];
        bias      = 15'd1023;
        frac      = {op_i[51:0], 60'd0};
      end
      default: begin
        sign_o    = op_i[127];
        bexp      = op_i[126:112];
        special_o = &op_i[126:112];
        bias      = 15'd16383;
        frac      = op_i[111:0];
      end
    endcase
    hidden = |bexp;
    exp_o  = $signed({3'd0, (hidden ? bexp : 15'd1)}) - $signed({3'd0, bias});
    sig_o  = {hidden, frac};
  end
endmodule

// File: rtl/fp2u_align.sv
module fp2u_align
  import fp2u_pkg::*;
(
  input  logic [SIG_W-1:0]        sig_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [1:0]              size_i,
  output logic [OP_W-1:0]         int_o,
  output logic                    half_o,
  output logic                    sticky_o,
  output logic                    big_o
);
  localparam logic signed [EXP_W-1:0] E_LO  = EXP_W'(-2);
  localparam logic signed [EXP_W-1:0] E_HI  = EXP_W'(FIX_W - 3);
  localparam logic signed [EXP_W-1:0] E_OFS = EXP_W'(2);

  logic [FIX_W-1:0]        fix;
  logic                    tiny;
  logic [7:0]              sh;
  logic signed [EXP_W-1:0] lim;

  always_comb begin
    fix  = '0;
    tiny = 1'b0;
    sh   = 8'(exp_i + E_OFS);
    if (exp_i < E_LO)       tiny = |sig_i;   // magnitude below one quarter
    else if (exp_i <= E_HI) fix = {{(FIX_W-SIG_W){1'b0}}, sig_i} << sh;
    // above E_HI every bit weighs 2^128 or more and vanishes modulo 2^N
    int_o    = fix[FIX_W-1:FRAC_W];
    half_o   = fix[FRAC_W-1];
    sticky_o = (|fix[FRAC_W-2:0]) | tiny;
    unique case (size_i)
      2'd0:    lim = EXP_W'(W_S);
      2'd1:    lim = EXP_W'(W_D);
      default: lim = EXP_W'(OP_W);
    endcase
    big_o = (exp_i >= lim);
  end
endmodule

// File: rtl/fp2u_round.sv
module fp2u_round
  import fp2u_pkg::*;
(
  input  logic [OP_W-1:0]   int_i,
  input  logic              half_i,
  input  logic              sticky_i,
  input  logic              big_i,
  input  logic              sign_i,
  input  logic              special_i,
  input  logic [2:0]        rm_i,
  input  logic [1:0]        size_i,
  output logic [OP_W-1:0]   res_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic            inc;
  logic            lost;
  logic [OP_W:0]   q;
  logic [OP_W-1:0] raw;
  logic [OP_W-1:0] mask;
  logic            hi_nz;
  logic            ovf;

  always_comb begin
    lost = half_i | sticky_i;
    unique case (rm_i)
      RM_TZ:   inc = 1'b0;
      RM_UP:   inc = ~sign_i & lost;
      RM_DN:   inc = sign_i & lost;
      RM_NA:   inc = half_i;
      default: inc = half_i & (sticky_i | int_i[0]);
    endcase
    q   = {1'b0, int_i} + {{OP_W{1'b0}}, inc};
    raw = sign_i ? (OP_W'(0) - q[OP_W-1:0]) : q[OP_W-1:0];
    unique case (size_i)
      2'd0: begin
        mask  = {{(OP_W-W_S){1'b0}}, {W_S{1'b1}}};
        hi_nz = |q[OP_W:W_S];
      end
      2'd1: begin
        mask  = {{(OP_W-W_D){1'b0}}, {W_D{1'b1}}};
        hi_nz = |q[OP_W:W_D];
      end
      default: begin
        mask  = {OP_W{1'b1}};
        hi_nz = q[OP_W];
      end
    endcase
    ovf = big_i | (sign_i ? (|q) : hi_nz);
    if (special_i) begin
      res_o   = '0;
      flags_o = 3'b100;
    end else begin
      res_o   = raw & mask;
      flags_o = {1'b0, ovf, lost};
    end
  end
endmodule

// File: rtl/fp2uint_wrap.sv
module fp2uint_wrap
  import fp2u_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_rmode,
  input  logic [OP_W-1:0]   in_operand,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic [TAG_W-1:0]  out_tag
);
  localparam int NDLY = 2;   // extra stages for the wider sizes

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  assign srst_n = rst_sync[1];

  // stage A: unpack
  logic                    u_sign, u_spec;
  logic signed [EXP_W-1:0] u_exp;
  logic [SIG_W-1:0]        u_sig;
  fp2u_unpack u_unpack (.op_i(in_operand), .size_i(in_size), .sign_o(u_sign),
                        .special_o(u_spec), .exp_o(u_exp), .sig_o(u_sig));

  logic                    a_vld, a_sign, a_spec;
  logic [1:0]              a_size;
  logic [2:0]              a_rm;
  logic [TAG_W-1:0]        a_tag;
  logic signed [EXP_W-1:0] a_exp;
  logic [SIG_W-1:0]        a_sig;

  // stage B: align
  logic [OP_W-1:0] l_int;
  logic            l_half, l_sticky, l_big;
  fp2u_align u_align (.sig_i(a_sig), .exp_i(a_exp), .size_i(a_size), .int_o(l_int),
                      .half_o(l_half), .sticky_o(l_sticky), .big_o(l_big));

  logic             b_vld, b_sign, b_spec, b_half, b_sticky, b_big;
  logic [1:0]       b_size;
  logic [2:0]       b_rm;
  logic [TAG_W-1:0] b_tag;
  logic [OP_W-1:0]  b_int;

  // stage C: round and pack
  logic [OP_W-1:0]   r_res;
  logic [FLAG_W-1:0] r_flags;
  fp2u_round u_round (.int_i(b_int), .half_i(b_half), .sticky_i(b_sticky), .big_i(b_big),
                      .sign_i(b_sign), .special_i(b_spec), .rm_i(b_rm), .size_i(b_size),
                      .res_o(r_res), .flags_o(r_flags));

  logic              c_vld;
  logic [1:0]        c_size;
  logic [TAG_W-1:0]  c_tag;
  logic [OP_W-1:0]   c_res;
  logic [FLAG_W-1:0] c_flags;

  // delay slots for 64/128-bit results
  logic              s_vld   [NDLY];
  logic [1:0]        s_size  [NDLY];
  logic [TAG_W-1:0]  s_tag   [NDLY];
  logic [OP_W-1:0]   s_res   [NDLY];
  logic [FLAG_W-1:0] s_flags [NDLY];

  // next-state: slot sources, pass enables, completions
  logic              src_vld   [NDLY];
  logic [1:0]        src_size  [NDLY];
  logic [TAG_W-1:0]  src_tag   [NDLY];
  logic [OP_W-1:0]   src_res   [NDLY];
  logic [FLAG_W-1:0] src_flags [NDLY];
  logic [NDLY-1:0]   pass;
  logic [NDLY:0]     done;

  always_comb begin
    for (int i = 0; i < NDLY; i++) begin
      src_vld[i]   = (i == 0) ? c_vld   : s_vld[i-1];
      src_size[i]  = (i == 0) ? c_size  : s_size[i-1];
      src_tag[i]   = (i == 0) ? c_tag   : s_tag[i-1];
      src_res[i]   = (i == 0) ? c_res   : s_res[i-1];
      src_flags[i] = (i == 0) ? c_flags : s_flags[i-1];
      pass[i]      = src_vld[i] && (extra_lat(src_size[i]) > 2'(i));
    end
    done[0] = c_vld && (extra_lat(c_size) == 2'd0);
    for (int i = 0; i < NDLY; i++)
      done[i+1] = s_vld[i] && (extra_lat(s_size[i]) == 2'(i + 1));
  end

  always_comb begin
    out_valid  = |done;
    out_result = '0;
    out_flags  = '0;
    out_tag    = '0;
    if (done[0]) begin
      out_result = c_res; out_flags = c_flags; out_tag = c_tag;
    end
    for (int i = 0; i < NDLY; i++)
      if (done[i+1]) begin
        out_result = s_res[i]; out_flags = s_flags[i]; out_tag = s_tag[i];
      end
  end

  // registers: valids reset, payload clock-enabled
  always_ff @(posedge clk or negedge srst_n)
    if (!srst_n) begin
      a_vld <= 1'b0;
      b_vld <= 1'b0;
      c_vld <= 1'b0;
      for (int i = 0; i < NDLY; i++) s_vld[i] <= 1'b0;
    end else begin
      a_vld <= in_valid;
      b_vld <= a_vld;
      c_vld <= b_vld;
      for (int i = 0; i < NDLY; i++) s_vld[i] <= pass[i];
    end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_size <= in_size;  a_rm   <= in_rmode; a_tag <= in_tag;
      a_sign <= u_sign;   a_spec <= u_spec;   a_exp <= u_exp;  a_sig <= u_sig;
    end
    if (a_vld) begin
      b_size <= a_size;   b_rm     <= a_rm;     b_tag <= a_tag;
      b_sign <= a_sign;   b_spec   <= a_spec;
      b_int  <= l_int;    b_half   <= l_half;   b_sticky <= l_sticky; b_big <= l_big;
    end
    if (b_vld) begin
      c_size <= b_size;   c_tag <= b_tag;  c_res <= r_res;  c_flags <= r_flags;
    end
    for (int i = 0; i < NDLY; i++)
      if (pass[i]) begin
        s_size[i]  <= src_size[i];
        s_tag[i]   <= src_tag[i];
        s_res[i]   <= src_res[i];
        s_flags[i] <= src_flags[i];
      end
  end

  // R9: never two completions in one cycle
  p_single_done_r9: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(done));

  // R6: latency and tag per size
  p_lat32_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_size == 2'd0) |-> ##3 (out_valid && out_tag == $past(in_tag, 3)));
  p_lat64_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_size == 2'd1) |-> ##4 (out_valid && out_tag == $past(in_tag, 4)));
  p_lat128_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_size[1]) |-> ##5 (out_valid && out_tag == $past(in_tag, 5)));

  // R7: invalid results carry nothing else
  p_invalid_clean_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && out_flags[2]) |-> (out_result == '0 && out_flags[1:0] == 2'b00));

  // R10: no result without an operation issued since reset
  p_quiet_reset_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!a_vld && !b_vld && !c_vld && !s_vld[0] && !s_vld[1]) |=> !out_valid);
endmodule

// File: tb/fp2uint_wrap_test.sv
module fp2uint_wrap_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_size = '0;
  logic [2:0] in_rmode = '0;
  logic [127:0] in_operand = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_valid;
  logic [127:0] out_result;
  logic [2:0] out_flags;
  logic [TAG_W-1:0] out_tag;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp2uint_wrap #(.TAG_W(TAG_W)) uut (.*);

  typedef struct packed {
    logic [7:0]   req;
    logic [1:0]   sz;
    logic [2:0]   rm;
    logic [127:0] op;
    logic [127:0] res;
    logic [2:0]   fl;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 2'd0, 3'd0, 128'h3F800000, 128'd1, 3'b000},                 // R1 1.0
    '{8'd2, 2'd0, 3'd0, 128'h40200000, 128'd2, 3'b001},                 // R2 2.5 nearest-even
    '{8'd2, 2'd0, 3'd1, 128'h40200000, 128'd2, 3'b001},                 // R2 toward zero
    '{8'd2, 2'd0, 3'd2, 128'h40200000, 128'd3, 3'b001},                 // R2 toward +inf
    '{8'd2, 2'd0, 3'd3, 128'h40200000, 128'd2, 3'b001},                 // R2 toward -inf
    '{8'd2, 2'd0, 3'd4, 128'h40200000, 128'd3, 3'b001},                 // R2 ties away
    '{8'd2, 2'd0, 3'd0, 128'h40600000, 128'd4, 3'b001},                 // R2 3.5 -> 4
    '{8'd2, 2'd0, 3'd7, 128'h40200000, 128'd2, 3'b001},                 // R2 reserved code
    '{8'd5, 2'd0, 3'd0, 128'h4F7FFFFF, 128'hFFFFFF00, 3'b000},          // R5 exact max
    '{8'd3, 2'd0, 3'd0, 128'h4F800000, 128'd0, 3'b010},                 // R3 2^32 wraps
    '{8'd3, 2'd0, 3'd0, 128'h4F800001, 128'h200, 3'b010},               // R3 2^32+512
    '{8'd4, 2'd0, 3'd0, 128'hBF800000, 128'hFFFFFFFF, 3'b010},          // R4 -1
    '{8'd4, 2'd0, 3'd0, 128'h80000000, 128'd0, 3'b000},                 // R4 -0
    '{8'd4, 2'd0, 3'd1, 128'hBF400000, 128'd0, 3'b001},                 // R4 -0.75 toward zero
    '{8'd4, 2'd0, 3'd0, 128'hBF400000, 128'hFFFFFFFF, 3'b011},          // R4 -0.75 nearest
    '{8'd7, 2'd0, 3'd0, 128'h7F800000, 128'd0, 3'b100},                 // R7 +inf
    '{8'd7, 2'd0, 3'd0, 128'hFFC00000, 128'd0, 3'b100},                 // R7 NaN
    '{8'd8, 2'd0, 3'd0, 128'h00000001, 128'd0, 3'b001},                 // R8 subnormal
    '{8'd8, 2'd0, 3'd2, 128'h00000001, 128'd1, 3'b001},                 // R8 up
    '{8'd8, 2'd0, 3'd3, 128'h80000001, 128'hFFFFFFFF, 3'b011},          // R8 neg down
    '{8'd1, 2'd0, 3'd0, {96'hDEADBEEF_01234567_89ABCDEF, 32'h3F800000}, 128'd1, 3'b000}, // R1 upper ignored
    '{8'd1, 2'd1, 3'd0, 128'h3FF8000000000000, 128'd2, 3'b001},         // R1 1.5 b64
    '{8'd3, 2'd1, 3'd0, 128'h43F0000000000001, 128'h1000, 3'b010},      // R3 2^64+4096
    '{8'd4, 2'd1, 3'd0, 128'hC000000000000000, 128'hFFFFFFFFFFFFFFFE, 3'b010}, // R4 -2
    '{8'd5, 2'd1, 3'd0, 128'h41EFFFFFFFF00000, 128'h100000000, 3'b001}, // R5 2^32-0.5
    '{8'd7, 2'd1, 3'd0, 128'h7FF8000000000000, 128'd0, 3'b100},         // R7 NaN b64
    '{8'd1, 2'd2, 3'd0, {16'h3FFF, 112'd0}, 128'd1, 3'b000},            // R1 1.0 b128
    '{8'd1, 2'd2, 3'd0, {16'h4063, 112'd0}, (128'd1 << 100), 3'b000},   // R1 2^100
    '{8'd4, 2'd2, 3'd0, {16'hBFFF, 112'd0}, {128{1'b1}}, 3'b010},       // R4 -1 b128
    '{8'd3, 2'd2, 3'd0, {16'h407F, 112'd0}, 128'd0, 3'b010},            // R3 2^128
    '{8'd2, 2'd2, 3'd4, {16'h3FFE, 112'd0}, 128'd1, 3'b001},            // R2 0.5 ties away
    '{8'd7, 2'd2, 3'd0, {16'h7FFF, 112'd0}, 128'd0, 3'b100},            // R7 inf b128
    '{8'd1, 2'd3, 3'd0, {16'h3FFF, 112'd0}, 128'd1, 3'b000}             // R1 code 3
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] sz, input logic [2:0] rm, input logic [127:0] op,
                         input logic [TAG_W-1:0] tg, output logic [127:0] res,
                         output logic [2:0] fl, output int lat, output logic [TAG_W-1:0] otg);
    int k;
    int guard;
    @(negedge clk);
    in_valid = 1'b1; in_size = sz; in_rmode = rm; in_operand = op; in_tag = tg;
    k = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    lat = out_valid ? (cyc - k) : -1;
    res = out_result; fl = out_flags; otg = out_tag;
    @(negedge clk);
  endtask

  real rv [0:6];

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] res;
    logic [2:0] fl;
    int lat;
    logic [TAG_W-1:0] otg;
    int exp_lat;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset", {127'd0, out_valid}, 128'd0);

    // table walk: R1..R8 values and flags, R6 latency and tag
    for (int i = 0; i < NV; i++) begin
      run_one(VECS[i].sz, VECS[i].rm, VECS[i].op, TAG_W'(i), res, fl, lat, otg);
      exp_lat = (VECS[i].sz == 2'd0) ? 3 : (VECS[i].sz == 2'd1) ? 4 : 5;
      chk($sformatf("R%0d vec %0d result", VECS[i].req, i), res, VECS[i].res);
      chk($sformatf("R%0d vec %0d flags", VECS[i].req, i), {125'd0, fl}, {125'd0, VECS[i].fl});
      chk($sformatf("R6 vec %0d latency", i), 128'(lat), 128'(exp_lat));
      chk($sformatf("R6 vec %0d tag", i), {124'd0, otg}, {124'd0, TAG_W'(i)});
    end

    // R2: binary64 ties-away against the simulator's own real-to-integer rounding
    rv[0] = 1.0; rv[1] = 2.5; rv[2] = 3.5; rv[3] = 1234567.49;
    rv[4] = 1.0e15 + 0.5; rv[5] = 0.49; rv[6] = 7.5;
    for (int i = 0; i < 7; i++) begin
      longint iv;
      iv = longint'(rv[i]);
      run_one(2'd1, 3'd4, {64'd0, $realtobits(rv[i])}, 4'd9, res, fl, lat, otg);
      chk($sformatf("R2 real %0d result", i), res, {64'd0, iv});
      chk($sformatf("R5 real %0d inexact", i), {127'd0, fl[0]},
          {127'd0, (real'(iv) != rv[i])});
    end

    // R9: 128-bit issued, then 32-bit next cycle; the short one leaves first
    begin
      int seen;
      logic [TAG_W-1:0] order [2];
      logic [127:0] vals [2];
      @(negedge clk);
      in_valid = 1'b1; in_size = 2'd2; in_rmode = 3'd0; in_operand = {16'hBFFF, 112'd0}; in_tag = 4'd5;
      @(negedge clk);
      in_size = 2'd0; in_operand = 128'h3F800000; in_tag = 4'd6;
      @(negedge clk);
      in_valid = 1'b0;
      seen = 0;
      for (int c = 0; c < 10; c++) begin
        if (out_valid && seen < 2) begin
          order[seen] = out_tag; vals[seen] = out_result; seen++;
        end
        @(negedge clk);
      end
      chk("R9 completions", 128'(seen), 128'd2);
      chk("R9 first tag", {124'd0, order[0]}, 128'd6);
      chk("R9 second tag", {124'd0, order[1]}, 128'd5);
      chk("R9 first value", vals[0], 128'd1);
      chk("R9 second value", vals[1], {128{1'b1}});
    end

    // R6: back-to-back 64-bit operations come out on consecutive cycles
    begin
      int first;
      int hits;
      first = -1; hits = 0;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        in_valid = 1'b1; in_size = 2'd1; in_rmode = 3'd0;
        in_operand = {64'd0, 64'h3FF0000000000000 + (64'(j + 1) << 52)};
        in_tag = TAG_W'(10 + j);
      end
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 10; c++) begin
        if (out_valid) begin
          if (first < 0) first = c;
          chk($sformatf("R6 stream tag %0d", hits), {124'd0, out_tag}, 128'(10 + c - first));
          chk($sformatf("R6 stream value %0d", hits), out_result, 128'(2 << (c - first)));
          hits++;
        end
        @(negedge clk);
      end
      chk("R6 stream count", 128'(hits), 128'd3);
    end

    chk("R10 idle at end", {127'd0, out_valid}, 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule